// File: doc/BRIEF.md
# SSI Absolute Position Serializer

This block sends a 17-bit absolute position word to a host over a synchronous serial interface. The host supplies the serial clock and, in three-wire operation, an active-low select. When a frame opens, the block takes a snapshot of the parallel position input. It then presents one bit per serial clock period, most significant bit first. Each bit is loaded on a rising serial clock edge, so the host reads it while the clock is low. A direction strap can make the reported value count down instead of up. For this, the word is replaced by its complement against the full 17-bit range at the moment it is captured.

The serial clock and select come from off chip and are asynchronous to the block. Both pass through synchronizer chains on the system clock, and all frame logic runs in the system clock domain. The system clock must run several times faster than the serial clock: 10 MHz is the serial clock limit in three-wire operation and about 1.5 MHz in two-wire operation. In two-wire point-to-point operation, select is tied low and has no effect. A frame then opens on the first falling serial clock edge. It closes when the clock has stayed high for a set number of system clocks (a monoflop), and capture is then armed again. The data line is modelled as a value plus an output enable for the pad. The position input and the straps are plain level ports with no handshake. They are read only at capture time.

Top module: `ssi_pos_tx`

## Requirements
- R1: In three-wire mode, a falling edge on select captures the position input. Changes to the position input during a frame do not alter the bits sent in that frame.
- R2: Each rising serial clock edge in a frame puts the next bit on sdo_o. The first bit is bit 16, then bit 15, down to bit 0, so 17 bits are sent MSB first.
- R3: When dir_down_i is 1 at capture, the word sent is 131071 minus the position input. When it is 0, the word sent is the position input unchanged.
- R4: From the 18th rising serial clock edge of a frame until the frame ends, sdo_o is 0.
- R5: In three-wire mode, while select is high, sdo_oe_o is 0 and serial clock edges are ignored: the next frame still starts with bit 16.
- R6: In two-wire mode, sdo_oe_o is always 1, the select input is ignored, and sdo_o is 1 between frames.
- R7: In two-wire mode, the first falling serial clock edge while armed captures the position. Keeping the serial clock high for IDLE_TIMEOUT system clocks ends the frame and re-arms capture. High phases shorter than this do not end the frame.
- R8: sdo_o changes only after a rising serial clock edge, a capture or a frame end, so it stays constant throughout each low phase of the serial clock.
- R9: After reset, sdo_o is 1. In three-wire mode, sdo_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ssi_clk_i | input | 1 | Serial clock from the host, idle high, asynchronous |
| ssi_sel_n_i | input | 1 | Active-low frame select from the host, asynchronous |
| pos_i | input | 17 | Parallel absolute position |
| dir_down_i | input | 1 | 1 = report the position counting down (value inverted against 2^17-1) |
| two_wire_i | input | 1 | 1 = two-wire mode: select ignored, frames closed by clock-idle timeout |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Output enable for the data pad (0 = high impedance) |

## Verification
Some properties are checked by assertions on every system clock. The data output may change only one cycle after a rising serial clock edge, a capture or a frame end. It must be 0 once all 17 bits are out. It must return high when a frame ends. In three-wire mode a high select must close the frame, and in two-wire mode a clock-high run of IDLE_TIMEOUT cycles must close it. Other properties are only visible as the host sees them, so the bench's frame scenarios cover them. These are that the bits come out in the right order for each position, that inversion gives the right value, and that a position change mid-frame has no effect. They also include that clock activity while select is high leaves no trace, that select is ignored in two-wire mode, and that back-to-back two-wire frames each capture a fresh value.

// File: rtl/ssi_pos_pkg.sv
package ssi_pos_pkg;

  // Width of the absolute position word
  localparam int unsigned POS_W = 17;

  // Frame controller state
  typedef enum logic {
    FR_IDLE   = 1'b0,
    FR_ACTIVE = 1'b1
  } frame_st_e;

endpackage

// File: rtl/ssi_pos_sync.sv
// Synchronizer chain for one asynchronous input. Gives the synchronized
// level and the level one system clock earlier, for edge detection.
module ssi_pos_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic prev_o
);

  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {(STAGES + 1){RST_VAL}};
    end else begin
      chain_q <= {chain_q[STAGES-1:0], async_i};
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign prev_o  = chain_q[STAGES];

endmodule

// File: rtl/ssi_pos_frame.sv
// Frame controller: decides when a frame opens (capture), when a bit
// advances and when the frame closes. This covers select-bounded
// three-wire frames and timeout-bounded two-wire frames.
module ssi_pos_frame
  import ssi_pos_pkg::*;
#(
  parameter int unsigned IDLE_TIMEOUT = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic two_wire_i,
  input  logic sel_s_i,
  input  logic sel_d_i,
  input  logic sclk_s_i,
  input  logic sclk_d_i,
  output logic cap_o,
  output logic adv_o,
  output logic end_o,
  output logic active_o
);

  localparam int unsigned IDLE_W = $clog2(IDLE_TIMEOUT + 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_TIMEOUT - 1);

  frame_st_e         st_q;
  logic [IDLE_W-1:0] idle_q;
  logic              sclk_rise, sclk_fall, sel_fall;
  logic              timeout_hit;
  logic              active;

  assign sclk_rise = sclk_s_i & ~sclk_d_i;
  assign sclk_fall = ~sclk_s_i & sclk_d_i;
  assign sel_fall  = ~sel_s_i & sel_d_i;
  assign active    = (st_q == FR_ACTIVE);

  assign timeout_hit = sclk_s_i && (idle_q == IDLE_LAST);

  always_comb begin
    cap_o = 1'b0;
    end_o = 1'b0;
    if (!active) begin
      cap_o = two_wire_i ? sclk_fall : sel_fall;
    end else begin
      end_o = two_wire_i ? timeout_hit : sel_s_i;
    end
  end

  assign adv_o    = active && sclk_rise && !end_o;
  assign active_o = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= FR_IDLE;
    end else if (cap_o) begin
      st_q <= FR_ACTIVE;
    end else if (end_o) begin
      st_q <= FR_IDLE;
    end
  end

  // Clock-high monoflop: counts system clocks while the serial clock is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
    end else if (!active || !sclk_s_i || end_o) begin
      idle_q <= '0;
    end else begin
      idle_q <= idle_q + 1'b1;
    end
  end

  // R5
  sel_high_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!two_wire_i && sel_s_i) |=> (st_q == FR_IDLE));

  // R7
  idle_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (two_wire_i && active && sclk_s_i && idle_q == IDLE_LAST) |=> (st_q == FR_IDLE));

endmodule

// File: rtl/ssi_pos_shift.sv
// Capture register and bit sequencer: snapshots the (optionally inverted)
// position and presents one bit per advance, MSB first, then zeros.
module ssi_pos_shift #(
  parameter int unsigned POS_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos_i,
  input  logic             dir_down_i,
  input  logic             cap_i,
  input  logic             adv_i,
  input  logic             end_i,
  input  logic             active_i,
  output logic             sdo_o
);

  localparam int unsigned      CNT_W   = $clog2(POS_W + 1);
  localparam logic [CNT_W-1:0] CNT_ALL = CNT_W'(POS_W);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic [POS_W-1:0] shreg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sdo_q;
  logic [POS_W-1:0] snap;

  assign snap = dir_down_i ? (POS_MAX - pos_i) : pos_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      sdo_q   <= 1'b1;
    end else if (cap_i) begin
      shreg_q <= snap;
      cnt_q   <= '0;
      sdo_q   <= 1'b1;
    end else if (end_i) begin
      cnt_q   <= '0;
      sdo_q   <= 1'b1;
    end else if (adv_i) begin
      if (cnt_q < CNT_ALL) begin
        sdo_q   <= shreg_q[POS_W-1];
        shreg_q <= {shreg_q[POS_W-2:0], 1'b0};
        cnt_q   <= cnt_q + 1'b1;
      end else begin
        sdo_q   <= 1'b0;
      end
    end
  end

  assign sdo_o = sdo_q;

  // R8
  sdo_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_q) |-> $past(adv_i || cap_i || end_i));

  // R4
  trail_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && adv_i && cnt_q == CNT_ALL) |=> !sdo_q);

  // R6
  end_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_i |=> sdo_q);

endmodule

// File: rtl/ssi_pos_tx.sv
// SSI absolute position serializer top.
module ssi_pos_tx
  import ssi_pos_pkg::*;
#(
  parameter int unsigned WORD_W       = POS_W,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned IDLE_TIMEOUT = 1250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ssi_clk_i,
  input  logic              ssi_sel_n_i,
  input  logic [WORD_W-1:0] pos_i,
  input  logic              dir_down_i,
  input  logic              two_wire_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);

  localparam int unsigned N_SYNC = 2;

  logic [N_SYNC-1:0] async_in, lvl, prv;
  logic              cap, adv, fin, active;

  assign async_in = {ssi_sel_n_i, ssi_clk_i};

  // Both external lines idle high
  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    ssi_pos_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b1)
    ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(async_in[g]),
      .level_o(lvl[g]),
      .prev_o (prv[g])
    );
  end

  ssi_pos_frame #(
    .IDLE_TIMEOUT(IDLE_TIMEOUT)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .two_wire_i(two_wire_i),
    .sel_s_i   (lvl[1]),
    .sel_d_i   (prv[1]),
    .sclk_s_i  (lvl[0]),
    .sclk_d_i  (prv[0]),
    .cap_o     (cap),
    .adv_o     (adv),
    .end_o     (fin),
    .active_o  (active)
  );

  ssi_pos_shift #(
    .POS_W(WORD_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .pos_i     (pos_i),
    .dir_down_i(dir_down_i),
    .cap_i     (cap),
    .adv_i     (adv),
    .end_i     (fin),
    .active_i  (active),
    .sdo_o     (sdo_o)
  );

  assign sdo_oe_o = two_wire_i | active;

  // R9
  idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!two_wire_i && !active) |-> !sdo_oe_o);

endmodule

// File: tb/ssi_pos_tx_test.sv
module ssi_pos_tx_test;

  localparam int HP  = 20;   // serial clock half period in system clocks
  localparam int TO  = 100;  // idle timeout used by the bench

  typedef struct packed {
    logic [16:0] pos;
    logic        dn;
    logic        tw;
    logic [16:0] exp;
  } vec_t;

  // R2 R3: plain and inverted words in both modes
  localparam vec_t VECS [7] = '{
    '{17'h00000, 1'b0, 1'b0, 17'h00000},
    '{17'h1FFFF, 1'b0, 1'b0, 17'h1FFFF},
    '{17'h15555, 1'b0, 1'b0, 17'h15555},
    '{17'h01234, 1'b1, 1'b0, 17'h1EDCB},
    '{17'h00000, 1'b1, 1'b1, 17'h1FFFF},
    '{17'h0ABCD, 1'b0, 1'b1, 17'h0ABCD},
    '{17'h10001, 1'b1, 1'b1, 17'h0FFFE}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1;
  logic        sel_n = 1'b1;
  logic [16:0] pos = '0;
  logic        dn = 1'b0;
  logic        tw = 1'b0;
  logic        sdo, sdo_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ssi_pos_tx #(.IDLE_TIMEOUT(TO)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ssi_clk_i  (sclk),
    .ssi_sel_n_i(sel_n),
    .pos_i      (pos),
    .dir_down_i (dn),
    .two_wire_i (tw),
    .sdo_o      (sdo),
    .sdo_oe_o   (sdo_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One complete frame: 18 clock periods, 17 data bits plus one trailer bit
  task automatic run_frame(input logic [16:0] p, input logic d, input logic t,
                           input bit late, input logic [16:0] late_p,
                           output logic [16:0] word, output logic trail,
                           output bit stable_ok);
    logic b1, b2;
    pos = p; dn = d; tw = t;
    stable_ok = 1'b1;
    word = '0;
    trail = 1'bx;
    wait_clk(10);
    if (!t) sel_n = 1'b0;
    wait_clk(HP);
    sclk = 1'b0;
    wait_clk(HP);
    for (int i = 0; i < 18; i++) begin
      sclk = 1'b1;
      wait_clk(HP);
      sclk = 1'b0;
      wait_clk(HP / 4);
      b1 = sdo;
      if (late && i == 2) pos = late_p;
      wait_clk(HP / 2);
      b2 = sdo;
      if (b1 !== b2) stable_ok = 1'b0;
      if (i < 17) word[16-i] = b1;
      else trail = b1;
      wait_clk(HP / 4);
    end
    sclk = 1'b1;
    wait_clk(HP);
    if (!t) sel_n = 1'b1;
    else wait_clk(TO + 20);
    wait_clk(10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [16:0] w;
    logic        tr;
    bit          st;

    // R9: reset state
    wait_clk(5);
    chk(sdo_oe === 1'b0, "R9", "oe in reset", 32'(sdo_oe), 0);
    rst_n = 1'b1;
    wait_clk(5);
    chk(sdo === 1'b1, "R9", "sdo after reset", 32'(sdo), 1);
    chk(sdo_oe === 1'b0, "R9", "oe after reset", 32'(sdo_oe), 0);

    // Vector table
    foreach (VECS[k]) begin
      run_frame(VECS[k].pos, VECS[k].dn, VECS[k].tw, 1'b0, '0, w, tr, st);
      chk(w === VECS[k].exp, "R2/R3", $sformatf("word vec %0d", k), 32'(w), 32'(VECS[k].exp));
      chk(tr === 1'b0, "R4", $sformatf("trailer vec %0d", k), 32'(tr), 0);
      chk(st, "R8", $sformatf("low-phase stability vec %0d", k), 32'(st), 1);
      if (VECS[k].tw) begin
        chk(sdo_oe === 1'b1 && sdo === 1'b1, "R7", "two-wire idle after timeout",
            {30'd0, sdo_oe, sdo}, 3);
      end else begin
        chk(sdo_oe === 1'b0, "R5", "oe after select high", 32'(sdo_oe), 0);
      end
    end

    // R5: clock edges with select high are ignored
    tw = 1'b0;
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b0; wait_clk(HP);
      sclk = 1'b1; wait_clk(HP);
    end
    chk(sdo_oe === 1'b0, "R5", "oe during ignored clocks", 32'(sdo_oe), 0);
    run_frame(17'h0F0F0, 1'b0, 1'b0, 1'b0, '0, w, tr, st);
    chk(w === 17'h0F0F0, "R5", "frame after ignored clocks", 32'(w), 32'h0F0F0);

    // R1: position change mid-frame has no effect
    run_frame(17'h13579, 1'b0, 1'b0, 1'b1, 17'h02468, w, tr, st);
    chk(w === 17'h13579, "R1", "word frozen at capture", 32'(w), 32'h13579);

    // R6: select ignored in two-wire mode
    tw = 1'b1;
    wait_clk(10);
    sel_n = 1'b0; wait_clk(HP);
    sel_n = 1'b1; wait_clk(HP);
    chk(sdo_oe === 1'b1 && sdo === 1'b1, "R6", "two-wire select toggle",
        {30'd0, sdo_oe, sdo}, 3);
    sel_n = 1'b0;

    // R7: back-to-back two-wire frames re-arm after timeout
    run_frame(17'h1C3A5, 1'b0, 1'b1, 1'b0, '0, w, tr, st);
    chk(w === 17'h1C3A5, "R7", "two-wire frame A", 32'(w), 32'h1C3A5);
    run_frame(17'h0005A, 1'b1, 1'b1, 1'b0, '0, w, tr, st);
    chk(w === 17'h1FFA5, "R7", "two-wire frame B inverted", 32'(w), 32'h1FFA5);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule